// File: doc/BRIEF.md
# Parallel Half-Band-Rate Pulse-Shaping Interpolator (x2, five symbols per beat)

This block is the shaping filter for one rail of a QPSK transmitter whose converter consumes far more samples per clock than one. On every accepted clock beat it takes five 1-bit symbols and returns ten shaped multi-bit samples, which is an interpolation factor of two. The response is a square-root raised-cosine FIR whose quantised taps are a parameter. The second rail uses a separate instance of the same block.

The zeros that interpolation places between symbols are never stored and never multiplied. Each output position has its own hardware path. An even output position sums the even-indexed taps and an odd position sums the odd-indexed taps, each over the symbol history that ends at the matching input lane. That history reaches back into symbols from earlier beats, which a small register keeps. Each symbol becomes a level of +1 or -1, so every product reduces to adding or subtracting a tap. All ten sums are registered and appear together one cycle after the beat that produced them.

Top module: `shp_interp_x2`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `out_valid` is 0 and all ten output samples are 0.
- R2: An input bit of 0 counts as level +1 and an input bit of 1 counts as level -1.
- R3: Input lane k (bit k of `sym_in`) is the k-th oldest symbol of its beat. Output position q = 2k+p sits at bits [q*OW +: OW] of `samp_out` as a two's-complement value. It equals the sum over j of h[p+2j] times the level of the symbol j positions before lane k in the accepted stream. Here h[t] is tap t, taken from bits [t*CW +: CW] of `COEFS`.
- R4: The symbol window used by R3 spans accepted beats. Symbols from earlier beats add to the current outputs exactly as if the stream were continuous.
- R5: `out_valid` is 1 exactly in the cycle after a cycle in which `sym_valid` was 1 outside reset. The samples of that beat appear in the same cycle.
- R6: A cycle with `sym_valid` low changes neither the stored history nor the output samples, and `out_valid` is 0 in the cycle that follows.
- R7: A position that would refer to a symbol before the first beat accepted since reset contributes zero. The output equals a zero-insert-then-convolve model whose stream starts at reset.
- R8: A full-scale stream with every symbol at -1 gives, on each position, the exact negated sum of that position's taps, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | The five symbols on `sym_in` are accepted this cycle |
| sym_in | input | LANES (5) | Symbol bits, lane 0 oldest |
| out_valid | output | 1 | `samp_out` holds a new beat |
| samp_out | output | 2*LANES*OW (150) | Ten shaped samples, position 0 oldest, OW bits each |

## Verification
The assertions assume that `sym_valid` and `rst` are always 0 or 1 and never unknown after time zero. They also assume that reset is held for at least one clock edge before the first beat, so the history starts silent. The stimulus holds both assumptions. It drives every input on the falling edge, holds reset for several cycles at the start and once more in the middle of the run, and keeps `sym_valid` at a defined level in gaps. The stimulus mixes random bit beats, idle gaps, constant runs of each polarity and alternating patterns. Every position is compared with a serial zero-insert-then-convolve model.

// File: rtl/shp_pkg.sv
package shp_pkg;

    // Signal level carried through the history; ZERO marks "before stream start"
    typedef enum logic [1:0] {
        LVL_ZERO = 2'b00,
        LVL_POS  = 2'b01,
        LVL_NEG  = 2'b11
    } level_t;

    function automatic level_t bit_to_level(input logic b);
        return b ? LVL_NEG : LVL_POS;
    endfunction

    // Number of taps one polyphase branch uses
    function automatic int branch_len(input int ntaps, input int phase);
        return (ntaps - phase + 1) / 2;
    endfunction

endpackage

// File: rtl/shp_sym_map.sv
module shp_sym_map
    import shp_pkg::*;
#(
    parameter int LANES = 5
) (
    input  logic [LANES-1:0]   bits_in,
    output level_t [LANES-1:0] lvl_out
);

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_map
            assign lvl_out[k] = bit_to_level(bits_in[k]);
        end
    endgenerate

endmodule

// File: rtl/shp_tap_history.sv
module shp_tap_history
    import shp_pkg::*;
#(
    parameter int LANES = 5,
    parameter int HIST  = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    adv,
    input  level_t [LANES-1:0]      fresh,
    output level_t [HIST+LANES-1:0] window
);

    localparam int WLEN = HIST + LANES;

    level_t [HIST-1:0] hist_q;

    // window[0] is the oldest held symbol, window[WLEN-1] the newest input lane
    generate
        for (genvar i = 0; i < WLEN; i++) begin : g_win
            if (i < HIST) begin : g_old
                assign window[i] = hist_q[i];
            end else begin : g_new
                assign window[i] = fresh[i-HIST];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HIST; i++) hist_q[i] <= LVL_ZERO;
        end else if (adv) begin
            for (int i = 0; i < HIST; i++) hist_q[i] <= window[i+LANES];
        end
    end

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(hist_q)) else $error("history moved while idle"); // R6

endmodule

// File: rtl/shp_phase_branch.sv
module shp_phase_branch
    import shp_pkg::*;
#(
    parameter int            CW    = 12,
    parameter int            NTAPS = 13,
    parameter int            PH    = 0,
    parameter int            NSYM  = 7,
    parameter int            OW    = 15,
    parameter logic [NTAPS*CW-1:0] COEFS = '0
) (
    input  level_t [NSYM-1:0]     syms,   // syms[j] = symbol j positions back
    output logic signed [OW-1:0]  sum_out
);

    logic signed [CW-1:0] craw;
    logic signed [OW-1:0] cext;
    logic signed [OW-1:0] acc;

    always_comb begin
        acc  = '0;
        craw = '0;
        cext = '0;
        for (int j = 0; j < NSYM; j++) begin
            craw = COEFS[(PH+2*j)*CW +: CW];
            cext = {{(OW-CW){craw[CW-1]}}, craw};
            unique case (syms[j])
                LVL_POS: acc = acc + cext;
                LVL_NEG: acc = acc - cext;
                default: acc = acc;
            endcase
        end
    end

    assign sum_out = acc;

endmodule

// File: rtl/shp_interp_x2.sv
module shp_interp_x2
    import shp_pkg::*;
#(
    parameter int LANES = 5,
    parameter int CW    = 12,
    parameter int NTAPS = 13,
    parameter logic [NTAPS*CW-1:0] COEFS = {
        12'shFE1, 12'shFCC, 12'sh000, 12'sh0A0, 12'sh186, 12'sh258, 12'sh2BC,
        12'sh258, 12'sh186, 12'sh0A0, 12'sh000, 12'shFCC, 12'shFE1},
    localparam int NSYM0 = (NTAPS + 1) / 2,
    localparam int OW    = CW + $clog2(NSYM0),
    localparam int NOUT  = 2 * LANES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sym_valid,
    input  logic [LANES-1:0]     sym_in,
    output logic                 out_valid,
    output logic [NOUT*OW-1:0]   samp_out
);

    localparam int HIST = NSYM0 - 1;

    level_t [LANES-1:0]      lvl;
    level_t [HIST+LANES-1:0] window;
    logic signed [OW-1:0]    sums [NOUT];

    shp_sym_map #(.LANES(LANES)) u_map (
        .bits_in (sym_in),
        .lvl_out (lvl)
    );

    shp_tap_history #(.LANES(LANES), .HIST(HIST)) u_hist (
        .clk    (clk),
        .rst    (rst),
        .adv    (sym_valid),
        .fresh  (lvl),
        .window (window)
    );

    // One dedicated path per (lane, phase); no output interleaver
    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            for (genvar p = 0; p < 2; p++) begin : g_ph
                localparam int NS = branch_len(NTAPS, p);
                level_t [NS-1:0] taps_in;
                for (genvar j = 0; j < NS; j++) begin : g_sel
                    assign taps_in[j] = window[HIST+k-j];
                end
                shp_phase_branch #(
                    .CW(CW), .NTAPS(NTAPS), .PH(p), .NSYM(NS), .OW(OW), .COEFS(COEFS)
                ) u_br (
                    .syms    (taps_in),
                    .sum_out (sums[2*k+p])
                );
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            samp_out  <= '0;
        end else begin
            out_valid <= sym_valid;
            if (sym_valid) begin
                for (int q = 0; q < NOUT; q++) samp_out[q*OW +: OW] <= sums[q];
            end
        end
    end

    AST_OUT_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
        sym_valid |=> out_valid) else $error("missing out_valid"); // R5
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |=> !out_valid) else $error("spurious out_valid"); // R6
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |=> $stable(samp_out)) else $error("samples moved while idle"); // R6
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && samp_out == '0)) else $error("not cleared"); // R1

endmodule

// File: tb/tb_shp_interp_x2.sv
module tb_shp_interp_x2;

    localparam int LANES = 5;
    localparam int CW    = 12;
    localparam int NTAPS = 13;
    localparam int OW    = CW + $clog2((NTAPS + 1) / 2);
    localparam int NOUT  = 2 * LANES;
    localparam logic [NTAPS*CW-1:0] TAPS = {
        12'shFE1, 12'shFCC, 12'sh000, 12'sh0A0, 12'sh186, 12'sh258, 12'sh2BC,
        12'sh258, 12'sh186, 12'sh0A0, 12'sh000, 12'shFCC, 12'shFE1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sym_valid = 1'b0;
    logic [LANES-1:0] sym_in = '0;
    logic out_valid;
    logic [NOUT*OW-1:0] samp_out;

    int n_checks = 0;
    int n_fail   = 0;
    int lv [0:8191];
    int nsym = 0;
    int exp_q [$];
    logic [NOUT*OW-1:0] last_out = '0;
    bit   just_reset = 1'b0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    shp_interp_x2 #(.LANES(LANES), .CW(CW), .NTAPS(NTAPS), .COEFS(TAPS)) dut (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_in(sym_in),
        .out_valid(out_valid), .samp_out(samp_out)
    );

    function automatic int tap(input int t);
        logic signed [CW-1:0] v;
        v = TAPS[t*CW +: CW];
        return int'(v);
    endfunction

    // zero-inserted stream: even positions carry symbols, odd are zero (R7: none before start)
    function automatic int xup(input int i);
        if (i < 0 || (i % 2) != 0) return 0;
        if (i / 2 >= nsym) return 0;
        return lv[i/2];
    endfunction

    task automatic check(input string req, input int got, input int expv, input string what);
        n_checks++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sym_valid = 1'b0;
        nsym = 0;
        exp_q.delete();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        just_reset = 1'b1;
    endtask

    // driver: applies one beat and pushes the model's ten samples
    task automatic send(input logic [LANES-1:0] b, input bit v);
        @(negedge clk);
        sym_in = b; sym_valid = v;
        if (v) begin
            int base;
            base = nsym;
            for (int k = 0; k < LANES; k++) begin
                lv[nsym] = b[k] ? -1 : 1;   // R2 mapping
                nsym++;
            end
            for (int q = 0; q < NOUT; q++) begin
                int y;
                y = 0;
                for (int t = 0; t < NTAPS; t++) y += tap(t) * xup(2*base + q - t);
                exp_q.push_back(y);
            end
        end
    endtask

    // monitor: samples away from the active edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst && !done) begin
                if (just_reset) begin
                    just_reset = 1'b0;
                    check("R1", int'(out_valid), 0, "out_valid after reset");
                    check("R1", int'(samp_out == '0), 1, "samples zero after reset");
                end else if (out_valid) begin
                    check("R5", int'(sym_valid), 1, "out_valid follows accepted beat");
                    for (int q = 0; q < NOUT; q++) begin
                        logic signed [OW-1:0] s;
                        int e;
                        s = samp_out[q*OW +: OW];
                        e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'h7fffffff;
                        check("R3/R4/R7", int'(s), e, $sformatf("position %0d", q));
                    end
                end else begin
                    check("R5", int'(sym_valid), 0, "out_valid low after idle");
                    check("R6", int'(samp_out == last_out), 1, "samples held while idle");
                end
                last_out = samp_out;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R7: first beat sees only silent history
        send(5'b10110, 1'b1);
        // R2: all-zero bits (+1) and all-one bits (-1)
        repeat (4) send(5'b00000, 1'b1);
        // R8: full-scale negative run: steady state = -(sum of branch taps)
        repeat (4) send(5'b11111, 1'b1);
        // R6: gaps with changing garbage on sym_in
        send(5'b01010, 1'b0);
        send(5'b11100, 1'b0);
        // R4: alternating patterns across beat boundaries
        repeat (6) send(5'b01010, 1'b1);
        send(5'b10101, 1'b1);
        // random traffic with random gaps
        for (int i = 0; i < 300; i++) begin
            send(5'($urandom()), ($urandom() % 4) != 0);
        end
        // R1/R7 again: mid-run reset restarts the stream
        do_reset();
        send(5'b00111, 1'b1);
        for (int i = 0; i < 200; i++) send(5'($urandom()), ($urandom() % 3) != 0);
        send(5'b00000, 1'b0);
        send(5'b00000, 1'b0);
        @(negedge clk);
        check("R5", exp_q.size(), 0, "all expected beats produced");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule